// File: doc/BRIEF.md
# RS-485 UART Transmitter with Automatic Driver Turnaround

This block is the send half of an asynchronous serial port for a half-duplex RS-485 bus. Software pushes characters into a 16-entry queue through a write strobe. The block turns each character into a frame and clocks it out on `txd` at a rate set by a programmable clock divider. The frame is one low start bit, the data bits least significant first, and one high stop bit. In nine-bit mode the ninth bit comes straight from the written word, so addressed multi-drop protocols need no parity tricks and can still use the queue.

The transceiver enable `de` rises with the first start bit and stays high across characters that follow each other back to back. It falls only once the last stop bit has been on the line for a full bit period. At that same cycle `temt` rises, and with its enable set the done interrupt goes high, so firmware can release the bus without polling. Software can always read the fill level and a full flag. Separate interrupts report an empty queue and a queue at or below half full. A write into a full queue is dropped and latches a sticky overflow flag.

Top module: `uart_tx485`

## Requirements
- R1: After reset `txd` is 1, `de` is 0, `temt` and `thre` are 1, `fifo_level` is 0, and `fifo_full` and `overflow` are 0.
- R2: A frame is a start bit of 0, then data bits in order from bit 0 upward, then a stop bit of 1. Every bit holds for `baud_div`+1 clock cycles. The first start bit begins one cycle after the write that fills an empty idle queue.
- R3: When `nine_bit_en` is 1 as a frame is loaded, `wr_data[8]` is sent as a ninth data bit between bit 7 and the stop bit. When it is 0, `wr_data[8]` is not sent.
- R4: `de` is 1 from the first cycle of a start bit until the last stop bit ends. It stays 1 with no gap between queued characters, and whenever `de` is 0, `txd` is 1.
- R5: `temt` is 0 while a frame is on the line. It becomes 1, and `de` becomes 0, in the cycle after the stop bit of the last queued character has lasted its full period.
- R6: `thre` is 1 whenever the queue is empty, including while the last character is still being shifted out.
- R7: The queue holds 16 characters. `fifo_level` gives the number stored, and `fifo_full` is 1 exactly when `fifo_level` is 16.
- R8: A write while `fifo_full` is 1 is discarded and leaves `fifo_level` unchanged. It sets `overflow`, which stays 1 until `ovf_clr` is pulsed.
- R9: `irq_half` is `ie_half` AND (`fifo_level` <= 8). `irq_empty` is `ie_empty` AND (`fifo_level` == 0). `irq_done` is `ie_done` AND `temt`.
- R10: With its enable at 0, an interrupt output stays 0 whatever its condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | 16 | Clock cycles per bit minus one |
| nine_bit_en | input | 1 | Send a ninth data bit |
| wr_en | input | 1 | Character write strobe |
| wr_data | input | 9 | Character to queue |
| ovf_clr | input | 1 | Clears the overflow flag |
| ie_empty | input | 1 | Enable for the empty interrupt |
| ie_half | input | 1 | Enable for the half-full interrupt |
| ie_done | input | 1 | Enable for the transmitter-empty interrupt |
| txd | output | 1 | Serial line, idle high |
| de | output | 1 | RS-485 driver enable |
| thre | output | 1 | Queue empty |
| temt | output | 1 | Queue and shifter both empty |
| fifo_full | output | 1 | Queue full |
| fifo_level | output | 5 | Characters in the queue |
| overflow | output | 1 | Sticky dropped-write flag |
| irq_empty | output | 1 | Empty interrupt |
| irq_half | output | 1 | Half-full interrupt |
| irq_done | output | 1 | Transmitter-empty interrupt |

## Verification
A write shows in `fifo_level` one cycle later, and the start bit and `de` rise one cycle after that. With P = `baud_div`+1 and N frame bits, `temt` rises and `de` falls 1+N·P cycles after the write edge. The bench samples on the falling clock edge at exactly those counts. The serial monitor waits half a bit after each start edge, then samples once per P cycles at bit centres. Each frame it decodes is compared with the next entry in the scoreboard queue. The interrupt flags are combinational from registered state, so the bench checks them in the same cycle as the level they follow.

// File: rtl/uart_tx485_pkg.sv
package uart_tx485_pkg;
    localparam int CHAR_W  = 9;
    localparam int FRAME_W = CHAR_W + 2;
    localparam int IDX_W   = $clog2(FRAME_W);

    typedef struct packed {
        logic               busy;
        logic               txd;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   last;
        logic [FRAME_W-1:0] frame;
    } shift_st_t;
endpackage

// File: rtl/tx485_fifo.sv
module tx485_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    input  logic                         ovf_clr,
    output logic [W-1:0]                 dout,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] cnt;
        logic          ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full     = (st_q.cnt == LW'(DEPTH));
    assign empty    = (st_q.cnt == '0);
    assign level    = st_q.cnt;
    assign overflow = st_q.ovf;
    assign dout     = mem[st_q.rp];
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wp = (st_q.wp == AW'(DEPTH-1)) ? '0 : st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = (st_q.rp == AW'(DEPTH-1)) ? '0 : st_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (ovf_clr)          st_d.ovf = 1'b0;
        if (push && full)     st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= din;
    end

    // R7
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LW'(DEPTH));
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (level == $past(level)) && overflow);
    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);
endmodule

// File: rtl/tx485_baud.sv
module tx485_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == div);

    always_comb begin
        if (restart || tick) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tx485_shift.sv
module tx485_shift
    import uart_tx485_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              avail,
    input  logic              nine_mode,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              tick,
    output logic              pop,
    output logic              restart,
    output logic              txd,
    output logic              busy
);
    shift_st_t st_d, st_q;
    logic load;
    logic [IDX_W-1:0] nidx;

    assign txd     = st_q.txd;
    assign busy    = st_q.busy;
    assign pop     = load;
    assign restart = load;
    assign nidx    = st_q.idx + 1'b1;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        if (!st_q.busy) begin
            load = avail;
        end else if (tick) begin
            if (st_q.idx == st_q.last) begin
                if (avail) load = 1'b1;
                else begin
                    st_d.busy = 1'b0;
                    st_d.txd  = 1'b1;
                end
            end else begin
                st_d.idx = nidx;
                st_d.txd = st_q.frame[nidx];
            end
        end
        if (load) begin
            st_d.busy  = 1'b1;
            st_d.txd   = 1'b0;
            st_d.idx   = '0;
            st_d.last  = nine_mode ? IDX_W'(FRAME_W-1) : IDX_W'(FRAME_W-2);
            st_d.frame = {1'b1, (nine_mode ? char_in[8] : 1'b1), char_in[7:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.txd  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(tick) && !$past(load)) |-> (txd == $past(txd)));
    // R5
    stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (txd && $past(txd)));
endmodule

// File: rtl/uart_tx485.sv
module uart_tx485
    import uart_tx485_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DIV_W-1:0]           baud_div,
    input  logic                       nine_bit_en,
    input  logic                       wr_en,
    input  logic [CHAR_W-1:0]          wr_data,
    input  logic                       ovf_clr,
    input  logic                       ie_empty,
    input  logic                       ie_half,
    input  logic                       ie_done,
    output logic                       txd,
    output logic                       de,
    output logic                       thre,
    output logic                       temt,
    output logic                       fifo_full,
    output logic [$clog2(DEPTH+1)-1:0] fifo_level,
    output logic                       overflow,
    output logic                       irq_empty,
    output logic                       irq_half,
    output logic                       irq_done
);
    localparam int LW   = $clog2(DEPTH+1);
    localparam int HALF = DEPTH / 2;

    logic              empty, pop, restart, tick, busy;
    logic [CHAR_W-1:0] head;

    tx485_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .din(wr_data), .pop(pop),
        .ovf_clr(ovf_clr), .dout(head), .full(fifo_full), .empty(empty),
        .level(fifo_level), .overflow(overflow)
    );

    tx485_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .restart(restart), .div(baud_div), .tick(tick)
    );

    tx485_shift u_shift (
        .clk(clk), .rst_n(rst_n), .avail(!empty), .nine_mode(nine_bit_en),
        .char_in(head), .tick(tick), .pop(pop), .restart(restart),
        .txd(txd), .busy(busy)
    );

    assign de        = busy;
    assign thre      = empty;
    assign temt      = empty && !busy;
    assign irq_empty = ie_empty && empty;
    assign irq_half  = ie_half && (fifo_level <= LW'(HALF));
    assign irq_done  = ie_done && temt;

    // R4
    de_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> txd);
    // R9
    half_covers_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_half && irq_empty) |-> irq_half);
    // R5
    de_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(de) |-> thre);
endmodule

// File: tb/tb_uart_tx485.sv
module tb_uart_tx485;
    localparam int P = 4;

    logic clk = 0, rst_n = 0;
    logic [15:0] baud_div = 16'(P-1);
    logic nine_bit_en = 0, wr_en = 0, ovf_clr = 0;
    logic [8:0] wr_data = '0;
    logic ie_empty = 0, ie_half = 0, ie_done = 0;
    logic txd, de, thre, temt, fifo_full, overflow, irq_empty, irq_half, irq_done;
    logic [4:0] fifo_level;

    int checks = 0, errors = 0, de_rises = 0, frames = 0;
    bit done = 0;
    logic [9:0] exp_q[$];

    always #4 clk = ~clk;

    uart_tx485 dut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .nine_bit_en(nine_bit_en),
        .wr_en(wr_en), .wr_data(wr_data), .ovf_clr(ovf_clr), .ie_empty(ie_empty),
        .ie_half(ie_half), .ie_done(ie_done), .txd(txd), .de(de), .thre(thre),
        .temt(temt), .fifo_full(fifo_full), .fifo_level(fifo_level),
        .overflow(overflow), .irq_empty(irq_empty), .irq_half(irq_half),
        .irq_done(irq_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_char(input logic [8:0] d, input bit dropped);
        wr_en = 1; wr_data = d;
        if (!dropped) exp_q.push_back({nine_bit_en, d});
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            if (temt && exp_q.size() == 0) break;
            @(negedge clk);
        end
        repeat (P) @(negedge clk);
    endtask

    // de rising-edge counter
    initial begin
        logic prev = 0;
        forever begin
            @(negedge clk);
            if (de && !prev) de_rises++;
            prev = de;
        end
    end

    // scoreboard monitor: decode frames at bit centres
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (txd === 1'b0) begin
                logic [9:0] e;
                int nb;
                repeat (P/2) @(negedge clk);
                check(txd === 1'b0, "R2 start bit", txd, 0);
                if (exp_q.size() == 0) begin
                    check(0, "R2 unexpected frame", 1, 0);
                    e = '0;
                end else e = exp_q.pop_front();
                nb = e[9] ? 9 : 8;
                for (int b = 0; b < nb; b++) begin
                    repeat (P) @(negedge clk);
                    check(txd === e[b], (b == 8) ? "R3 ninth bit" : "R2 data bit", txd, e[b]);
                end
                repeat (P) @(negedge clk);
                check(txd === 1'b1, "R2 stop bit", txd, 1);
                frames++;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int r0;
        bit half_bad;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(txd == 1, "R1 txd", txd, 1);
        check(de == 0, "R1 de", de, 0);
        check(temt == 1 && thre == 1, "R1 temt/thre", {temt, thre}, 3);
        check(fifo_level == 0 && !fifo_full && !overflow, "R1 level/full/ovf",
              fifo_level, 0);

        // single 8-bit character, cycle-exact timing
        ie_done = 1;
        write_char(9'h0A5, 0);
        check(fifo_level == 1, "R7 level after write", fifo_level, 1);
        @(negedge clk);
        check(de == 1 && txd == 0, "R4 de with start", {de, txd}, 2);
        check(thre == 1 && fifo_level == 0, "R6 thre while shifting", thre, 1);
        check(temt == 0 && irq_done == 0, "R5 temt low while busy", temt, 0);
        repeat (10*P - 1) @(negedge clk);
        check(de == 1 && temt == 0, "R5 still in stop bit", {de, temt}, 2);
        @(negedge clk);
        check(de == 0 && temt == 1, "R5 release after stop", {de, temt}, 1);
        check(irq_done == 1, "R9 irq_done", irq_done, 1);
        wait_idle();

        // 9-bit mode, two back-to-back characters
        nine_bit_en = 1;
        r0 = de_rises;
        write_char(9'h1A5, 0);
        write_char(9'h05A, 0);
        wait_idle();
        check(de_rises - r0 == 1, "R4 no gap between chars", de_rises - r0, 1);
        nine_bit_en = 0;
        write_char(9'h13C, 0);
        wait_idle();
        check(frames == 4, "R3 8-bit ignores bit 8", frames, 4);

        // burst to full, overflow, half and empty interrupts
        ie_half = 1; ie_empty = 1;
        r0 = de_rises;
        for (int i = 0; i < 17; i++) write_char(9'(8'h30 + i), 0);
        check(fifo_full == 1 && fifo_level == 16, "R7 full at 16", fifo_level, 16);
        check(irq_half == 0 && irq_empty == 0, "R9 irqs low when full",
              {irq_half, irq_empty}, 0);
        write_char(9'h0EE, 1);
        check(overflow == 1, "R8 overflow set", overflow, 1);
        check(fifo_level == 16, "R8 dropped write", fifo_level, 16);
        repeat (3) @(negedge clk);
        check(overflow == 1, "R8 overflow sticky", overflow, 1);
        ovf_clr = 1; @(negedge clk); ovf_clr = 0;
        check(overflow == 0, "R8 overflow cleared", overflow, 0);
        half_bad = 0;
        for (int i = 0; i < 3000; i++) begin
            if (irq_half !== (fifo_level <= 8)) half_bad = 1;
            if (fifo_level == 0) break;
            @(negedge clk);
        end
        check(!half_bad, "R9 irq_half tracks level", half_bad, 0);
        check(irq_empty == 1 && thre == 1, "R9 irq_empty", irq_empty, 1);
        wait_idle();
        check(de_rises - r0 == 1, "R4 de held over burst", de_rises - r0, 1);
        check(frames == 21, "R2 all burst frames", frames, 21);

        // enables off
        ie_done = 0; ie_half = 0; ie_empty = 0;
        @(negedge clk);
        check(!irq_done && !irq_half && !irq_empty, "R10 masked irqs",
              {irq_done, irq_half, irq_empty}, 0);
        check(temt == 1 && de == 0 && txd == 1, "R5 idle after burst", temt, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule